// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block watches the stream of conversion results as each one is stored and raises a sticky flag once a chosen channel has produced a programmed number of consecutive results on one side of a 12-bit threshold. Each comparison unit has its own configuration: an enable, an interrupt enable, a direction (strictly below the threshold, or at or above it), a channel select, a 4-bit hit count and the threshold itself. The number of units is a parameter and defaults to two, with fully independent state.

A unit tests a result only when it is enabled and the stored result belongs to its selected channel. A passing result advances an internal run counter. A failing result on that channel restarts the run. Results from other channels leave the run untouched. When the run length reaches the hit count plus one, the flag sets and the counter returns to zero. The counter then stays frozen until software clears the flag with a write-1-to-clear pulse. The interrupt output is the OR of every flag whose interrupt enable is set.

Bus decoding and the conversion engine are outside this block. The config fields arrive as separate ports, already decoded from the control word. In that word the enable is bit 0, the interrupt enable bit 1, the direction bit 2, the channel bits 7:3, the hit count bits 11:8 and the threshold bits 27:16.

Top module: `adc_cmp_monitor`

## Requirements
- R1: After reset, every flag and the interrupt output are 0.
- R2: With direction 0, a result strictly less than the threshold counts as a hit.
- R3: With direction 1, a result greater than or equal to the threshold counts as a hit.
- R4: With hit count N (4 bits), the flag becomes 1 after the clock edge that stores the (N+1)th consecutive hit. N = 0 flags on the first hit.
- R5: A selected-channel result that is not a hit restarts the run from zero.
- R6: Results stored for any other channel leave the run length unchanged.
- R7: While a flag is 1, its counter is held at zero and results are ignored. After the flag clears, a full run of N+1 new hits is needed to set it again.
- R8: A 1 on a unit's clear input while its flag is 1 clears the flag at the next edge. Without a clear, the flag stays 1. A clear while the flag is 0 does not disturb the run.
- R9: While a unit's enable is 0, no result changes its flag.
- R10: The interrupt output is 1 exactly when some unit has its flag at 1 and its interrupt enable at 1.
- R11: The channel select is 5 bits wide. Only channels 0 to 7 and 15 to 17 can match. A select of 8 to 14 or above 17 never matches any result.
- R12: Units are independent. Unit u uses the slices [u*5 +: 5] of the channel bus, [u*4 +: 4] of the count bus, [u*12 +: 12] of the threshold bus, and bit u of the other vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | A result is being stored this cycle |
| res_chan_i | input | 5 | Channel of the stored result |
| res_data_i | input | 12 | Stored conversion value |
| cmp_en_i | input | NUM_UNITS | Per-unit compare enable |
| cmp_irq_en_i | input | NUM_UNITS | Per-unit interrupt enable |
| cmp_cond_i | input | NUM_UNITS | Per-unit direction: 0 below, 1 at or above |
| cmp_chan_i | input | NUM_UNITS*5 | Per-unit channel select |
| cmp_mcnt_i | input | NUM_UNITS*4 | Per-unit hit count N |
| cmp_thr_i | input | NUM_UNITS*12 | Per-unit threshold |
| flag_clr_i | input | NUM_UNITS | Per-unit write-1-to-clear pulse |
| flag_o | output | NUM_UNITS | Sticky compare flags |
| irq_o | output | 1 | Combined compare interrupt |

## Verification
The assertions assume that config fields change only between result strobes. They also assume that a clear pulse is a plain level sampled at the clock, so a clear and a stored result may coincide in one cycle. The bench follows both assumptions. It drives every input half a cycle away from the active edge and rewrites the random configuration only at fixed intervals. The random stimulus keeps the hit count small and puts most results on or near the selected channel and threshold, so runs, restarts, flags and clears all occur often. Reserved and out-of-range selects are mixed in on purpose.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;

  localparam int DATA_W = 12;
  localparam int CHAN_W = 5;
  localparam int MCNT_W = 4;

  typedef enum logic {
    CMP_BELOW       = 1'b0,
    CMP_AT_OR_ABOVE = 1'b1
  } cmp_dir_e;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_RESTART,
    ACT_ADVANCE,
    ACT_FIRE,
    ACT_FROZEN
  } ctr_act_e;

  // True when a select value names a channel that can carry results
  function automatic logic chan_usable(input logic [CHAN_W-1:0] sel,
                                       input int num_chan,
                                       input int rsv_lo,
                                       input int rsv_hi);
    int s;
    s = int'(sel);
    return (s < num_chan) && !((s >= rsv_lo) && (s <= rsv_hi));
  endfunction

  // Direction-dependent threshold test
  function automatic logic dir_passes(input cmp_dir_e dir,
                                      input logic [DATA_W-1:0] value,
                                      input logic [DATA_W-1:0] thr);
    logic below;
    below = (value < thr);
    return (dir == CMP_AT_OR_ABOVE) ? !below : below;
  endfunction

  // The run is complete when the counter already holds N hits
  function automatic logic run_complete(input logic [MCNT_W-1:0] run,
                                        input logic [MCNT_W-1:0] need);
    return run == need;
  endfunction

endpackage

// File: rtl/adc_cmp_chan_filter.sv
module adc_cmp_chan_filter
  import adc_cmp_pkg::*;
#(
  parameter int NUM_CHAN = 18,
  parameter int RSV_LO   = 8,
  parameter int RSV_HI   = 14
) (
  input  logic              res_valid,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic              unit_en,
  input  logic [CHAN_W-1:0] unit_chan,
  output logic              sample_evt
);

  logic sel_ok;
  logic chan_eq;

  assign sel_ok     = chan_usable(unit_chan, NUM_CHAN, RSV_LO, RSV_HI);
  assign chan_eq    = (res_chan == unit_chan);
  assign sample_evt = res_valid && unit_en && sel_ok && chan_eq;

endmodule

// File: rtl/adc_cmp_cond_eval.sv
module adc_cmp_cond_eval
  import adc_cmp_pkg::*;
(
  input  logic              dir_bit,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] thr,
  output logic              cond_hit
);

  cmp_dir_e dir;

  assign dir      = cmp_dir_e'(dir_bit);
  assign cond_hit = dir_passes(dir, value, thr);

endmodule

// File: rtl/adc_cmp_match_ctr.sv
module adc_cmp_match_ctr
  import adc_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_evt,
  input  logic              cond_hit,
  input  logic [MCNT_W-1:0] need_cnt,
  input  logic              flag_clr,
  output logic              flag_q
);

  logic [MCNT_W-1:0] run_q;
  ctr_act_e          act;

  always_comb begin
    act = ACT_HOLD;
    if (flag_q) begin
      act = ACT_FROZEN;
    end else if (sample_evt) begin
      if (!cond_hit) begin
        act = ACT_RESTART;
      end else if (run_complete(run_q, need_cnt)) begin
        act = ACT_FIRE;
      end else begin
        act = ACT_ADVANCE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_FROZEN: begin
          run_q <= '0;
          if (flag_clr) flag_q <= 1'b0;
        end
        ACT_RESTART: run_q <= '0;
        ACT_ADVANCE: run_q <= run_q + 1'b1;
        ACT_FIRE: begin
          run_q  <= '0;
          flag_q <= 1'b1;
        end
        default: run_q <= run_q;
      endcase
    end
  end

endmodule

// File: rtl/adc_cmp_monitor.sv
module adc_cmp_monitor
  import adc_cmp_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int NUM_CHAN  = 18,
  parameter int RSV_LO    = 8,
  parameter int RSV_HI    = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        res_valid_i,
  input  logic [CHAN_W-1:0]           res_chan_i,
  input  logic [DATA_W-1:0]           res_data_i,
  input  logic [NUM_UNITS-1:0]        cmp_en_i,
  input  logic [NUM_UNITS-1:0]        cmp_irq_en_i,
  input  logic [NUM_UNITS-1:0]        cmp_cond_i,
  input  logic [NUM_UNITS*CHAN_W-1:0] cmp_chan_i,
  input  logic [NUM_UNITS*MCNT_W-1:0] cmp_mcnt_i,
  input  logic [NUM_UNITS*DATA_W-1:0] cmp_thr_i,
  input  logic [NUM_UNITS-1:0]        flag_clr_i,
  output logic [NUM_UNITS-1:0]        flag_o,
  output logic                        irq_o
);

  logic [NUM_UNITS-1:0] unit_evt;
  logic [NUM_UNITS-1:0] unit_hit;
  logic [NUM_UNITS-1:0] unit_irq;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    adc_cmp_chan_filter #(
      .NUM_CHAN (NUM_CHAN),
      .RSV_LO   (RSV_LO),
      .RSV_HI   (RSV_HI)
    ) filt_i (
      .res_valid  (res_valid_i),
      .res_chan   (res_chan_i),
      .unit_en    (cmp_en_i[u]),
      .unit_chan  (cmp_chan_i[u*CHAN_W +: CHAN_W]),
      .sample_evt (unit_evt[u])
    );

    adc_cmp_cond_eval eval_i (
      .dir_bit  (cmp_cond_i[u]),
      .value    (res_data_i),
      .thr      (cmp_thr_i[u*DATA_W +: DATA_W]),
      .cond_hit (unit_hit[u])
    );

    adc_cmp_match_ctr ctr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_evt (unit_evt[u]),
      .cond_hit   (unit_hit[u]),
      .need_cnt   (cmp_mcnt_i[u*MCNT_W +: MCNT_W]),
      .flag_clr   (flag_clr_i[u]),
      .flag_q     (flag_o[u])
    );

    assign unit_irq[u] = flag_o[u] & cmp_irq_en_i[u];
  end

  assign irq_o = |unit_irq;

endmodule

// File: rtl/adc_cmp_monitor_chk.sv
module adc_cmp_monitor_chk
  import adc_cmp_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int NUM_CHAN  = 18,
  parameter int RSV_LO    = 8,
  parameter int RSV_HI    = 14
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        res_valid_i,
  input logic [CHAN_W-1:0]           res_chan_i,
  input logic [NUM_UNITS-1:0]        cmp_en_i,
  input logic [NUM_UNITS-1:0]        cmp_irq_en_i,
  input logic [NUM_UNITS*CHAN_W-1:0] cmp_chan_i,
  input logic [NUM_UNITS-1:0]        flag_clr_i,
  input logic [NUM_UNITS-1:0]        flag_o,
  input logic                        irq_o,
  input logic [NUM_UNITS-1:0]        unit_evt,
  input logic [NUM_UNITS-1:0]        unit_hit
);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(flag_o & cmp_irq_en_i));

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_o & cmp_irq_en_i)) |-> irq_o);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[u] && !flag_clr_i[u]) |=> flag_o[u]);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[u] && flag_clr_i[u]) |=> !flag_o[u]);

    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[u]) |-> $past(unit_evt[u] && unit_hit[u]));

    // R9
    evt_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unit_evt[u] |-> (cmp_en_i[u] && res_valid_i));

    // R11
    evt_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unit_evt[u] |-> ((res_chan_i == cmp_chan_i[u*CHAN_W +: CHAN_W]) &&
                       chan_usable(res_chan_i, NUM_CHAN, RSV_LO, RSV_HI)));
  end

endmodule

bind adc_cmp_monitor adc_cmp_monitor_chk #(
  .NUM_UNITS (NUM_UNITS),
  .NUM_CHAN  (NUM_CHAN),
  .RSV_LO    (RSV_LO),
  .RSV_HI    (RSV_HI)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid_i  (res_valid_i),
  .res_chan_i   (res_chan_i),
  .cmp_en_i     (cmp_en_i),
  .cmp_irq_en_i (cmp_irq_en_i),
  .cmp_chan_i   (cmp_chan_i),
  .flag_clr_i   (flag_clr_i),
  .flag_o       (flag_o),
  .irq_o        (irq_o),
  .unit_evt     (unit_evt),
  .unit_hit     (unit_hit)
);

// File: tb/adc_cmp_monitor_tb_top.sv
module adc_cmp_monitor_tb_top;

  localparam int N = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          res_valid;
  logic [4:0]    res_chan;
  logic [11:0]   res_data;
  logic [N-1:0]  cmp_en, cmp_ie, cmp_cond, clr;
  logic [N*5-1:0]  cmp_chan;
  logic [N*4-1:0]  cmp_mcnt;
  logic [N*12-1:0] cmp_thr;
  logic [N-1:0]  flag_o;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench copies of configuration and reference state
  bit c_en[N], c_ie[N], c_cond[N];
  int c_chan[N], c_mc[N], c_thr[N];
  int m_run[N];
  bit m_flag[N];

  always #5 clk = ~clk;

  adc_cmp_monitor #(.NUM_UNITS(N)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .res_valid_i (res_valid), .res_chan_i (res_chan), .res_data_i (res_data),
    .cmp_en_i (cmp_en), .cmp_irq_en_i (cmp_ie), .cmp_cond_i (cmp_cond),
    .cmp_chan_i (cmp_chan), .cmp_mcnt_i (cmp_mcnt), .cmp_thr_i (cmp_thr),
    .flag_clr_i (clr), .flag_o (flag_o), .irq_o (irq_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit usable(input int c);
    return (c <= 7) || (c >= 15 && c <= 17);
  endfunction

  function automatic bit passes(input bit dir, input int v, input int t);
    if (dir) return v >= t;
    return v < t;
  endfunction

  task automatic set_unit(input int u, input bit en, input bit ie, input bit dir,
                          input int ch, input int mc, input int thr);
    c_en[u] = en; c_ie[u] = ie; c_cond[u] = dir;
    c_chan[u] = ch; c_mc[u] = mc; c_thr[u] = thr;
    cmp_en[u] = en; cmp_ie[u] = ie; cmp_cond[u] = dir;
    cmp_chan[u*5 +: 5] = ch[4:0];
    cmp_mcnt[u*4 +: 4] = mc[3:0];
    cmp_thr[u*12 +: 12] = thr[11:0];
  endtask

  task automatic compare_all(input string tag);
    bit exp_irq;
    exp_irq = 0;
    for (int u = 0; u < N; u++) begin
      check(flag_o[u] == m_flag[u], tag, flag_o[u], m_flag[u]);
      if (m_flag[u] && c_ie[u]) exp_irq = 1;
    end
    check(irq_o == exp_irq, tag, irq_o, exp_irq);
  endtask

  // Drive one cycle at a falling edge, advance the model, compare at the next
  task automatic step(input bit v, input int ch, input int d, input logic [N-1:0] cl,
                      input string tag);
    res_valid = v; res_chan = ch[4:0]; res_data = d[11:0]; clr = cl;
    for (int u = 0; u < N; u++) begin
      if (m_flag[u]) begin
        m_run[u] = 0;
        if (cl[u]) m_flag[u] = 0;
      end else if (v && c_en[u] && usable(c_chan[u]) && (ch == c_chan[u])) begin
        if (!passes(c_cond[u], d, c_thr[u])) m_run[u] = 0;
        else if (m_run[u] == c_mc[u]) begin m_run[u] = 0; m_flag[u] = 1; end
        else m_run[u]++;
      end
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic expect_flag(input int u, input bit v, input string tag);
    check(flag_o[u] == v, tag, flag_o[u], v);
  endtask

  task automatic do_reset();
    rst_n = 0; res_valid = 0; res_chan = 0; res_data = 0; clr = '0;
    for (int u = 0; u < N; u++) begin
      set_unit(u, 0, 0, 0, 0, 0, 0);
      m_run[u] = 0; m_flag[u] = 0;
    end
    repeat (3) @(negedge clk);
    check(flag_o == '0, "R1 flags after reset", flag_o, 0);
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    rst_n = 1;
  endtask

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    do_reset();

    // R2 and R4: below-threshold direction, N=2 needs three hits
    set_unit(0, 1, 1, 0, 3, 2, 12'h800);
    step(1, 3, 12'h100, '0, "R2");  expect_flag(0, 0, "R4 after 1 hit");
    step(1, 3, 12'h7FF, '0, "R2");  expect_flag(0, 0, "R4 after 2 hits");
    step(1, 3, 12'h000, '0, "R2");  expect_flag(0, 1, "R4 after 3 hits");
    step(1, 3, 12'h800, '0, "R2");  expect_flag(0, 1, "R2 equal is no hit");

    // R3 and R4 with N=0: at-or-above, equal value flags at once
    do_reset();
    set_unit(0, 1, 0, 1, 5, 0, 12'h400);
    step(1, 5, 12'h3FF, '0, "R3");  expect_flag(0, 0, "R3 below no hit");
    step(1, 5, 12'h400, '0, "R3");  expect_flag(0, 1, "R4 N=0 first hit");

    // R5: a miss restarts the run
    do_reset();
    set_unit(0, 1, 0, 0, 2, 2, 12'h800);
    step(1, 2, 12'h010, '0, "R5");
    step(1, 2, 12'h020, '0, "R5");
    step(1, 2, 12'h900, '0, "R5");
    step(1, 2, 12'h030, '0, "R5");
    step(1, 2, 12'h040, '0, "R5");  expect_flag(0, 0, "R5 run restarted");
    step(1, 2, 12'h050, '0, "R5");  expect_flag(0, 1, "R5 third fresh hit");

    // R6: other channels leave the run alone
    do_reset();
    set_unit(0, 1, 0, 0, 3, 1, 12'h800);
    step(1, 3, 12'h001, '0, "R6");
    step(1, 5, 12'hF00, '0, "R6");
    step(1, 5, 12'h001, '0, "R6");  expect_flag(0, 0, "R6 foreign hits");
    step(1, 3, 12'h001, '0, "R6");  expect_flag(0, 1, "R6 run kept");

    // R7: frozen while flagged, full run needed afterwards
    step(1, 3, 12'h001, '0, "R7");
    step(1, 3, 12'h001, '0, "R7");  expect_flag(0, 1, "R7 stays set");
    step(0, 0, 0, 2'b01, "R7");     expect_flag(0, 0, "R8 cleared");
    step(1, 3, 12'h001, '0, "R7");  expect_flag(0, 0, "R7 one hit after clear");
    step(1, 3, 12'h001, '0, "R7");  expect_flag(0, 1, "R7 full run");

    // R8: clear while flag is 0 keeps the run
    do_reset();
    set_unit(0, 1, 0, 0, 3, 1, 12'h800);
    step(1, 3, 12'h001, '0, "R8");
    step(0, 0, 0, 2'b01, "R8");
    step(1, 3, 12'h001, '0, "R8");  expect_flag(0, 1, "R8 clear on idle flag");

    // R9: disabled unit never flags
    do_reset();
    set_unit(0, 0, 1, 0, 4, 0, 12'h800);
    step(1, 4, 12'h001, '0, "R9");
    step(1, 4, 12'h002, '0, "R9");  expect_flag(0, 0, "R9 disabled");
    set_unit(0, 1, 1, 0, 4, 0, 12'h800);
    step(1, 4, 12'h001, '0, "R9");  expect_flag(0, 1, "R9 enabled");

    // R10: interrupt follows its enable
    set_unit(0, 1, 0, 0, 4, 0, 12'h800);
    step(0, 0, 0, '0, "R10");       check(irq_o == 0, "R10 ie off", irq_o, 0);
    set_unit(0, 1, 1, 0, 4, 0, 12'h800);
    step(0, 0, 0, '0, "R10");       check(irq_o == 1, "R10 ie on", irq_o, 1);

    // R11: reserved and out-of-range selects never match
    do_reset();
    set_unit(0, 1, 0, 0, 9, 0, 12'h800);
    set_unit(1, 1, 0, 0, 20, 0, 12'h800);
    step(1, 9, 12'h001, '0, "R11");
    step(1, 20, 12'h001, '0, "R11"); expect_flag(0, 0, "R11 select 9");
    expect_flag(1, 0, "R11 select 20");
    set_unit(0, 1, 0, 0, 17, 0, 12'h800);
    step(1, 17, 12'h001, '0, "R11"); expect_flag(0, 1, "R11 select 17");

    // R12: units keep separate state
    do_reset();
    set_unit(0, 1, 1, 0, 1, 0, 12'h100);
    set_unit(1, 1, 0, 1, 6, 1, 12'h100);
    step(1, 6, 12'h200, '0, "R12");
    step(1, 1, 12'h050, '0, "R12");  expect_flag(0, 1, "R12 unit0");
    expect_flag(1, 0, "R12 unit1 mid run");
    step(1, 6, 12'h300, 2'b01, "R12"); expect_flag(1, 1, "R12 unit1");
    expect_flag(0, 0, "R12 unit0 cleared");

    // Random phase
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int u, ch, d;
      logic [N-1:0] cl;
      if (i % 64 == 0) begin
        for (int k = 0; k < N; k++) begin
          int sel;
          sel = ($urandom % 8 == 0) ? int'($urandom % 24) : int'($urandom % 8);
          set_unit(k, ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                   sel, $urandom % 4, 12'h200 + ($urandom % 12'h800));
        end
      end
      u = $urandom % N;
      ch = ($urandom % 10 < 7) ? c_chan[u] : int'($urandom % 24);
      d = ($urandom % 4 == 0) ? int'($urandom % 4096) : c_thr[u] - 8 + int'($urandom % 16);
      if (d < 0) d = 0;
      if (d > 4095) d = 4095;
      cl = '0;
      for (int k = 0; k < N; k++) cl[k] = ($urandom % 10 == 0);
      step($urandom % 5 != 0, ch, d, cl, "R2/R3/R4/R5/R6/R7/R8/R12 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule